// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 512K words by 8 bits. The host offers one word access at a time over a valid/ready handshake. The block turns each access into active-low chip-select, write-strobe and read-strobe levels on the memory pins, and handles the shared data bus through separate out, drive-enable and in signals. It counts every phase of an access in whole clock cycles. The phase lengths come from parameters that the integrator sets at elaboration. Each one must be at least 1 cycle, and at least the memory's nanosecond limit divided by the clock period, rounded up.

The controller has six states: IDLE, RD_ACCESS, RD_TURNAROUND, WR_SETUP, WR_PULSE and WR_RECOVER.
- A read goes IDLE -> RD_ACCESS on an accepted request with the write flag low. It goes RD_ACCESS -> RD_TURNAROUND when the access count expires, and RD_TURNAROUND -> IDLE when the turnaround count expires.
- A write goes IDLE -> WR_SETUP on an accepted request with the write flag high. It then goes WR_SETUP -> WR_PULSE after one cycle, WR_PULSE -> WR_RECOVER when the pulse count expires, and WR_RECOVER -> IDLE after one cycle.

During a write the read strobe stays high, so the shorter write-pulse limit applies. The write always ends with the write strobe rising while chip-select is still low. The data drivers turn on only while the memory's outputs are disabled, and they turn off in the same cycle that the write strobe rises.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high, and on the first clock edge after it, chip-select, write strobe and read strobe are all high (1), the data drive-enable is 0 and the read-data-valid pulse is 0. After reset the ready output is 1.
- R2: Ready is 1 only in IDLE. A request is accepted on a rising clock edge where valid and ready are both 1. Ready is 0 from the cycle after acceptance until the access completes.
- R3: A read holds chip-select low, read strobe low and write strobe high for exactly RD_ACCESS_CYC cycles. The data-bus input is sampled at the end of that window. The sampled word appears on the read-data output together with a single-cycle read-data-valid pulse.
- R4: After the read window, chip-select and read strobe are both high for TURN_CYC cycles before ready returns, so a read occupies RD_ACCESS_CYC + TURN_CYC cycles.
- R5: A write holds chip-select low through three phases: one setup cycle with the write strobe high, then the write strobe low for max(WR_PULSE_CYC, WR_DATA_SETUP_CYC) cycles, then one recovery cycle with the write strobe high. A write occupies that count plus 2 cycles.
- R6: The read strobe is high for every cycle of a write.
- R7: The data drive-enable is 1 exactly in the cycles when the write strobe is low. It is never 1 while the read strobe is low.
- R8: While the data drive-enable is 1, the driven word stays constant. It equals the write data accepted with the request.
- R9: While chip-select is low, the memory address stays constant. It equals the address accepted with the request.
- R10: In IDLE all three strobes are high, which puts the memory in standby.
- R11: After a request is accepted, changes on the host address, write data and write flag have no effect on the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data |
| rsp_valid | output | 1 | One-cycle pulse when rsp_rdata is valid |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Chip-select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
Two events fall in the same clock cycle, and each pair is checked:
- At the end of a write, the write strobe rises and the data drivers release in the same cycle.
- At the end of a read, the data is sampled and the read strobe rises in the same cycle.

The bench's memory model latches write data while the write strobe is low and commits it on the strobe's rising edge. It drives read data only while the read strobe is low. If either pair drifted by one cycle, the result would be a corrupted word on readback or a contention flag from the per-cycle monitor. A sweep writes every address of a 16-word configuration, reads it all back, then repeats with complemented patterns. It counts the strobe-low cycles and the busy cycles of every access against the parameter values.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        IDLE,
        RD_ACCESS,
        RD_TURNAROUND,
        WR_SETUP,
        WR_PULSE,
        WR_RECOVER
    } ctrl_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } pin_levels_t;

    localparam pin_levels_t PINS_QUIET = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    function automatic pin_levels_t levels_for(ctrl_state_e s);
        pin_levels_t p;
        p = PINS_QUIET;
        unique case (s)
            IDLE:          p = PINS_QUIET;
            RD_ACCESS:     p = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
            RD_TURNAROUND: p = PINS_QUIET;
            WR_SETUP:      p = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
            WR_PULSE:      p = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
            WR_RECOVER:    p = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
            default:       p = PINS_QUIET;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (!expired) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sram_req_hold.sv
module sram_req_hold #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (take) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] word_q,
    output logic              valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= sample;
            if (sample) begin
                word_q <= bus_in;
            end
        end
    end
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC    = 2,
    parameter int TURN_CYC  = 1,
    parameter int PULSE_LEN = 1,
    parameter int CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_fire,
    input  logic             req_write,
    input  logic             phase_done,
    output logic             phase_load,
    output logic [CNT_W-1:0] phase_val,
    output logic             rd_sample,
    output logic             in_idle,
    output logic             ce_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             drive
);
    localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LAST  = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_LEN - 1);

    ctrl_state_e state_q, state_d;
    pin_levels_t pins_d;

    // Next-state logic and phase-counter loads
    always_comb begin
        state_d    = state_q;
        phase_load = 1'b0;
        phase_val  = '0;
        rd_sample  = 1'b0;
        unique case (state_q)
            IDLE: begin
                if (req_fire) begin
                    if (req_write) begin
                        state_d = WR_SETUP;
                    end else begin
                        state_d    = RD_ACCESS;
                        phase_load = 1'b1;
                        phase_val  = RD_LAST;
                    end
                end
            end
            RD_ACCESS: begin
                if (phase_done) begin
                    rd_sample  = 1'b1;
                    state_d    = RD_TURNAROUND;
                    phase_load = 1'b1;
                    phase_val  = TURN_LAST;
                end
            end
            RD_TURNAROUND: begin
                if (phase_done) begin
                    state_d = IDLE;
                end
            end
            WR_SETUP: begin
                state_d    = WR_PULSE;
                phase_load = 1'b1;
                phase_val  = PULSE_LAST;
            end
            WR_PULSE: begin
                if (phase_done) begin
                    state_d = WR_RECOVER;
                end
            end
            WR_RECOVER: begin
                state_d = IDLE;
            end
            default: begin
                state_d = IDLE;
            end
        endcase
    end

    assign pins_d  = levels_for(state_d);
    assign in_idle = (state_q == IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered pin levels, decoded from the next state so they match state_q
    always_ff @(posedge clk) begin
        if (rst) begin
            ce_n  <= PINS_QUIET.ce_n;
            we_n  <= PINS_QUIET.we_n;
            oe_n  <= PINS_QUIET.oe_n;
            drive <= PINS_QUIET.drive;
        end else begin
            ce_n  <= pins_d.ce_n;
            we_n  <= pins_d.we_n;
            oe_n  <= pins_d.oe_n;
            drive <= pins_d.drive;
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
    parameter int ADDR_W            = 19,
    parameter int DATA_W            = 8,
    parameter int RD_ACCESS_CYC     = 2,
    parameter int TURN_CYC          = 1,
    parameter int WR_PULSE_CYC      = 1,
    parameter int WR_DATA_SETUP_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int PULSE_LEN = (WR_PULSE_CYC > WR_DATA_SETUP_CYC) ? WR_PULSE_CYC : WR_DATA_SETUP_CYC;
    localparam int LEN_A     = (PULSE_LEN > RD_ACCESS_CYC) ? PULSE_LEN : RD_ACCESS_CYC;
    localparam int MAX_LEN   = (LEN_A > TURN_CYC) ? LEN_A : TURN_CYC;
    localparam int CNT_W     = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

    logic             req_fire;
    logic             phase_load;
    logic [CNT_W-1:0] phase_val;
    logic             phase_done;
    logic             rd_sample;
    logic             in_idle;

    assign req_ready = in_idle;
    assign req_fire  = req_valid && in_idle;

    sram_ctrl_fsm #(
        .RD_CYC   (RD_ACCESS_CYC),
        .TURN_CYC (TURN_CYC),
        .PULSE_LEN(PULSE_LEN),
        .CNT_W    (CNT_W)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .req_fire  (req_fire),
        .req_write (req_write),
        .phase_done(phase_done),
        .phase_load(phase_load),
        .phase_val (phase_val),
        .rd_sample (rd_sample),
        .in_idle   (in_idle),
        .ce_n      (mem_ce_n),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .drive     (mem_dq_oe)
    );

    sram_phase_timer #(
        .CNT_W(CNT_W)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .load    (phase_load),
        .load_val(phase_val),
        .expired (phase_done)
    );

    sram_req_hold #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) hold_i (
        .clk    (clk),
        .rst    (rst),
        .take   (req_fire),
        .addr_in(req_addr),
        .data_in(req_wdata),
        .addr_q (mem_addr),
        .data_q (mem_dq_out)
    );

    sram_rd_capture #(
        .DATA_W(DATA_W)
    ) cap_i (
        .clk    (clk),
        .rst    (rst),
        .sample (rd_sample),
        .bus_in (mem_dq_in),
        .word_q (rsp_rdata),
        .valid_q(rsp_valid)
    );
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int PULSE_LEN = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    logic [15:0] we_low_cnt;

    always_ff @(posedge clk) begin
        if (rst || mem_we_n) begin
            we_low_cnt <= '0;
        end else begin
            we_low_cnt <= we_low_cnt + 16'd1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid));

    assert_ready_means_standby_R10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_rsp_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_pulse_length_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low_cnt == 16'(PULSE_LEN)));

    assert_write_ends_chip_low_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> !mem_ce_n);

    assert_oe_high_in_write_R6: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    assert_release_with_we_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> !mem_dq_oe);

    assert_drive_only_we_low_R7: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> !mem_we_n);

    assert_wdata_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PULSE_LEN(PULSE_LEN)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int RD    = 2;
    localparam int TURN  = 1;
    localparam int PULSE = 2;
    localparam int DSET  = 3;
    localparam int PL    = (PULSE > DSET) ? PULSE : DSET;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_ready, req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata, rsp_rdata;
    logic          rsp_valid;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    int tests = 0;
    int fails = 0;
    int mon_contention = 0;
    int mon_hold = 0;

    logic [DW-1:0] sram [WORDS];
    logic [DW-1:0] shadow [WORDS];
    logic [DW-1:0] wr_latch = '0;

    always #5 clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .RD_ACCESS_CYC(RD), .TURN_CYC(TURN),
        .WR_PULSE_CYC(PULSE), .WR_DATA_SETUP_CYC(DSET)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: latch bus while write strobe low, commit on its rise
    always @(mem_ce_n or mem_we_n or mem_dq_oe or mem_dq_out) begin
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) wr_latch = mem_dq_out;
    end
    always @(posedge mem_we_n) begin
        if (!mem_ce_n) sram[mem_addr] = wr_latch;
    end
    assign mem_dq_in = (!mem_ce_n && mem_we_n && !mem_oe_n) ? sram[mem_addr] : 8'hC3;

    // Per-cycle monitor
    logic [DW-1:0] prev_dq;
    logic          prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dq_oe && !mem_oe_n) mon_contention++;
            if (mem_dq_oe != !mem_we_n) mon_contention++;
            if (mem_dq_oe && prev_oe && mem_dq_out != prev_dq) mon_hold++;
        end
        prev_oe = mem_dq_oe;
        prev_dq = mem_dq_out;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int busy, we_low, oe_low, addr_bad;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_addr = ~a; req_wdata = ~d;
        busy = 0; we_low = 0; oe_low = 0; addr_bad = 0;
        while (!req_ready && busy < 100) begin
            busy++;
            if (!mem_we_n) we_low++;
            if (!mem_oe_n) oe_low++;
            if (!mem_ce_n && mem_addr != a) addr_bad++;
            @(negedge clk);
        end
        shadow[a] = d;
        check(busy == PL + 2, "R5 write occupancy", busy, PL + 2);
        check(we_low == PL, "R5 write strobe low cycles", we_low, PL);
        check(oe_low == 0, "R6 read strobe low during write", oe_low, 0);
        check(addr_bad == 0, "R9 address during write", addr_bad, 0);
        check(mem_ce_n && mem_we_n && mem_oe_n, "R10 standby after write",
              {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string tag);
        int busy, oe_low, pulses, addr_bad;
        logic [DW-1:0] got;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'h99;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b1; req_addr = ~a;
        check(!req_ready, "R2 ready drops after accept", req_ready, 0);
        busy = 0; oe_low = 0; pulses = 0; addr_bad = 0; got = '0;
        while (!req_ready && busy < 100) begin
            busy++;
            if (!mem_oe_n) oe_low++;
            if (!mem_ce_n && mem_addr != a) addr_bad++;
            if (rsp_valid) begin pulses++; got = rsp_rdata; end
            @(negedge clk);
        end
        if (rsp_valid) pulses++;
        check(oe_low == RD, "R3 read strobe low cycles", oe_low, RD);
        check(busy == RD + TURN, "R4 read occupancy", busy, RD + TURN);
        check(pulses == 1, "R3 read valid pulses", pulses, 1);
        check(got == shadow[a], tag, got, shadow[a]);
        check(addr_bad == 0, "R9 address during read", addr_bad, 0);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) begin sram[i] = '0; shadow[i] = '0; end
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
              "R1 reset pin levels", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 14);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready, "R1 ready after reset", req_ready, 1);
        check(mem_ce_n && mem_we_n && mem_oe_n, "R10 standby when idle",
              {mem_ce_n, mem_we_n, mem_oe_n}, 7);

        // Pass 1: arithmetic pattern; host inputs scrambled after accept (R11)
        for (int a = 0; a < WORDS; a++) do_write(AW'(a), DW'(a * 37 + 5));
        for (int a = 0; a < WORDS; a++) do_read(AW'(a), "R11 readback ignores post-accept inputs");

        // Pass 2: complemented pattern, descending order
        for (int a = WORDS - 1; a >= 0; a--) do_write(AW'(a), ~DW'(a * 37 + 5));
        for (int a = 0; a < WORDS; a++) do_read(AW'(a), "R8 readback of driven word");

        // Interleaved write-then-read on the same word, extreme values
        do_write(AW'(WORDS - 1), 8'hFF);
        do_read(AW'(WORDS - 1), "R3 read after write 0xFF");
        do_write('0, 8'h00);
        do_read('0, "R3 read after write 0x00");

        check(mon_contention == 0, "R7 bus drive vs strobes", mon_contention, 0);
        check(mon_hold == 0, "R8 driven word stable", mon_hold, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule